// File: doc/BRIEF.md
# Masked Priority DMA Request Arbiter

This block decides which DMA channel the transfer sequencer serves next. Every channel offers three request sources: a single-transfer line and a burst-transfer line from its peripheral, and a software request strobe. Each source is qualified by the channel's enable, request-mask and burst-only settings, and the requests that pass are latched as pending.

When the sequencer reports idle and the controller is globally enabled, the arbiter picks one candidate channel. Channels marked high priority are preferred, and within a level the lowest channel number wins. It then presents a one-cycle grant pulse, together with a one-hot grant vector, the encoded channel number and a flag telling whether the service is a burst or a single transfer. The grant vector stays set until the sequencer signals completion. At that point the serviced channel's peripheral pending state is dropped. A software request is always served as a burst, bypasses the request mask, and stays pending until its channel has been granted.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, grant_vld is 0, grant_oh is all zeros and no request is pending.
- R2: A channel whose req_mask bit is 1 latches nothing from single_req or burst_req.
- R3: A channel whose burst_only bit is 1 latches nothing from single_req, and a burst_req on it is still served.
- R4: A 1 on sw_req bit i makes channel i pending as a burst request, even when its mask bit is 1. That request stays pending until channel i is granted. A 0 on sw_req creates nothing.
- R5: While chan_en bit i is 0, channel i latches no request from any source and is never granted. A request it latched earlier waits until the channel is enabled again.
- R6: When any candidate channel has its hi_prio bit at 1, the grant goes to a high-priority channel.
- R7: Among the candidates of the selected priority level, the lowest channel number is granted.
- R8: A grant is issued only when master_en and seq_idle are both 1 and no channel is in service. grant_vld is then 1 for exactly one cycle. grant_oh holds exactly the granted bit, with bit i standing for channel i, until completion, and grant_idx holds the binary channel number.
- R9: grant_burst is 1 when the granted channel had a burst or software request pending, and 0 when only a single request was pending.
- R10: A svc_done pulse while a channel is in service clears grant_oh on the next cycle and drops that channel's pending single and burst requests. Its software request was already dropped at grant.
- R11: A request sampled at clock edge k on an idle, enabled arbiter is granted at edge k+1.
- R12: svc_done while no channel is in service has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Global enable for granting |
| chan_en | input | NUM_CH | Per-channel enable |
| req_mask | input | NUM_CH | Per-channel mask of peripheral request lines |
| burst_only | input | NUM_CH | Per-channel: ignore single requests |
| hi_prio | input | NUM_CH | Per-channel high-priority select |
| single_req | input | NUM_CH | Peripheral single-transfer requests |
| burst_req | input | NUM_CH | Peripheral burst-transfer requests |
| sw_req | input | NUM_CH | Software request strobes |
| seq_idle | input | 1 | Sequencer ready to accept a grant |
| svc_done | input | 1 | Sequencer finished the granted service |
| grant_vld | output | 1 | One-cycle pulse on a new grant |
| grant_oh | output | NUM_CH | One-hot channel in service, zero when none |
| grant_idx | output | CH_W | Binary number of the last granted channel |
| grant_burst | output | 1 | Last grant is a burst service |

## Verification
The bench builds the block with its default of eight channels, so the encoded index spans three bits. High-priority channels can then sit above or below default ones in channel number, which puts the case where priority level overrides channel order within reach. Directed sequences cover masking, burst-only filtering, disabled channels and software requests held across a busy period. A long randomized run, in which the settings change every few dozen cycles, compares every output cycle by cycle against a behavioural model.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    KIND_SINGLE = 1'b0,
    KIND_BURST  = 1'b1
  } svc_kind_e;
endpackage

// File: rtl/dma_req_filter.sv
module dma_req_filter #(
  parameter int NUM_CH = 8
) (
  input  logic [NUM_CH-1:0] chan_en,
  input  logic [NUM_CH-1:0] req_mask,
  input  logic [NUM_CH-1:0] burst_only,
  input  logic [NUM_CH-1:0] single_req,
  input  logic [NUM_CH-1:0] burst_req,
  input  logic [NUM_CH-1:0] sw_req,
  output logic [NUM_CH-1:0] set_single,
  output logic [NUM_CH-1:0] set_burst,
  output logic [NUM_CH-1:0] set_soft
);
  // One qualification slice per channel
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_slice
    logic ext_ok;
    assign ext_ok         = chan_en[ch] & ~req_mask[ch];
    assign set_single[ch] = ext_ok & ~burst_only[ch] & single_req[ch];
    assign set_burst[ch]  = ext_ok & burst_req[ch];
    assign set_soft[ch]   = chan_en[ch] & sw_req[ch];
  end
endmodule

// File: rtl/dma_pend_store.sv
module dma_pend_store #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_single,
  input  logic [NUM_CH-1:0] set_burst,
  input  logic [NUM_CH-1:0] set_soft,
  input  logic [NUM_CH-1:0] clr_ext,
  input  logic [NUM_CH-1:0] clr_soft,
  output logic [NUM_CH-1:0] pend_single,
  output logic [NUM_CH-1:0] pend_burst,
  output logic [NUM_CH-1:0] pend_soft
);
  // New requests win over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_single <= '0;
      pend_burst  <= '0;
      pend_soft   <= '0;
    end else begin
      pend_single <= (pend_single & ~clr_ext) | set_single;
      pend_burst  <= (pend_burst & ~clr_ext) | set_burst;
      pend_soft   <= (pend_soft & ~clr_soft) | set_soft;
    end
  end

  // R4
  sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_soft & ~clr_soft) & ~pend_soft) == '0));
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cand,
  input  logic [NUM_CH-1:0] hi_prio,
  output logic              pick_any,
  output logic [NUM_CH-1:0] pick_oh,
  output logic [CH_W-1:0]   pick_idx
);
  function automatic logic [NUM_CH-1:0] lowest_bit(input logic [NUM_CH-1:0] v);
    return v & (~v + NUM_CH'(1));
  endfunction

  function automatic logic [CH_W-1:0] encode(input logic [NUM_CH-1:0] oh);
    logic [CH_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (oh[i]) r = r | CH_W'(i);
    return r;
  endfunction

  logic [NUM_CH-1:0] cand_hi;
  logic [NUM_CH-1:0] pool;
  logic              use_hi;

  assign cand_hi  = cand & hi_prio;
  assign use_hi   = |cand_hi;
  assign pool     = use_hi ? cand_hi : cand;
  assign pick_oh  = lowest_bit(pool);
  assign pick_idx = encode(pick_oh);
  assign pick_any = |cand;

  // R6
  pick_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cand & hi_prio)) |-> (|(pick_oh & hi_prio)));
  // R7
  pick_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pick_oh & ~cand) == '0) && $onehot0(pick_oh));
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_en,
  input  logic [NUM_CH-1:0] chan_en,
  input  logic [NUM_CH-1:0] req_mask,
  input  logic [NUM_CH-1:0] burst_only,
  input  logic [NUM_CH-1:0] hi_prio,
  input  logic [NUM_CH-1:0] single_req,
  input  logic [NUM_CH-1:0] burst_req,
  input  logic [NUM_CH-1:0] sw_req,
  input  logic              seq_idle,
  input  logic              svc_done,
  output logic              grant_vld,
  output logic [NUM_CH-1:0] grant_oh,
  output logic [CH_W-1:0]   grant_idx,
  output logic              grant_burst
);
  import dma_arb_pkg::*;

  logic [NUM_CH-1:0] set_single, set_burst, set_soft;
  logic [NUM_CH-1:0] pend_single, pend_burst, pend_soft;
  logic [NUM_CH-1:0] clr_ext, clr_soft, cand;
  logic [NUM_CH-1:0] pick_oh;
  logic [CH_W-1:0]   pick_idx;
  logic              pick_any;

  // Named events for the checks
  logic      in_service;
  logic      fire;
  logic      done_evt;
  svc_kind_e pick_kind;

  logic              gnt_vld_q;
  logic [NUM_CH-1:0] gnt_oh_q;
  logic [CH_W-1:0]   gnt_idx_q;
  svc_kind_e         gnt_kind_q;

  dma_req_filter #(.NUM_CH(NUM_CH)) u_filter (
    .chan_en(chan_en), .req_mask(req_mask), .burst_only(burst_only),
    .single_req(single_req), .burst_req(burst_req), .sw_req(sw_req),
    .set_single(set_single), .set_burst(set_burst), .set_soft(set_soft)
  );

  dma_pend_store #(.NUM_CH(NUM_CH)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_single(set_single), .set_burst(set_burst), .set_soft(set_soft),
    .clr_ext(clr_ext), .clr_soft(clr_soft),
    .pend_single(pend_single), .pend_burst(pend_burst), .pend_soft(pend_soft)
  );

  assign cand = chan_en & ((pend_single & ~burst_only) | pend_burst | pend_soft);

  dma_prio_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .cand(cand), .hi_prio(hi_prio),
    .pick_any(pick_any), .pick_oh(pick_oh), .pick_idx(pick_idx)
  );

  assign in_service = |gnt_oh_q;
  assign fire       = master_en & seq_idle & ~in_service & pick_any;
  assign done_evt   = in_service & svc_done;
  assign pick_kind  = (|(pick_oh & (pend_burst | pend_soft))) ? KIND_BURST : KIND_SINGLE;
  assign clr_ext    = done_evt ? gnt_oh_q : '0;
  assign clr_soft   = fire ? pick_oh : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_vld_q  <= 1'b0;
      gnt_oh_q   <= '0;
      gnt_idx_q  <= '0;
      gnt_kind_q <= KIND_SINGLE;
    end else begin
      gnt_vld_q <= fire;
      if (fire) begin
        gnt_oh_q   <= pick_oh;
        gnt_idx_q  <= pick_idx;
        gnt_kind_q <= pick_kind;
      end else if (done_evt) begin
        gnt_oh_q <= '0;
      end
    end
  end

  assign grant_vld   = gnt_vld_q;
  assign grant_oh    = gnt_oh_q;
  assign grant_idx   = gnt_idx_q;
  assign grant_burst = (gnt_kind_q == KIND_BURST);

  // R8
  grant_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> $past(master_en && seq_idle));
  // R8
  grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |=> !grant_vld);
  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_oh) && (!grant_vld || $countones(grant_oh) == 1));
  // R10
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (grant_oh == '0));
  // R5
  grant_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> ((grant_oh & ~$past(chan_en)) == '0));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    // R2
    burst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_burst[ch]) |-> $past(chan_en[ch] && !req_mask[ch] && burst_req[ch]));
    // R3
    single_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_single[ch]) |->
        $past(chan_en[ch] && !req_mask[ch] && !burst_only[ch] && single_req[ch]));
    // R4
    soft_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_soft[ch]) |-> $past(chan_en[ch] && sw_req[ch]));
  end
endmodule

// File: tb/test_dma_req_arbiter.sv
module test_dma_req_arbiter;
  localparam int N = 8;
  localparam int W = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, master_en, seq_idle, svc_done;
  logic [N-1:0] chan_en, req_mask, burst_only, hi_prio, single_req, burst_req, sw_req;
  logic grant_vld, grant_burst;
  logic [N-1:0] grant_oh;
  logic [W-1:0] grant_idx;

  dma_req_arbiter #(.NUM_CH(N)) i_dma_req_arbiter (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .chan_en(chan_en),
    .req_mask(req_mask), .burst_only(burst_only), .hi_prio(hi_prio),
    .single_req(single_req), .burst_req(burst_req), .sw_req(sw_req),
    .seq_idle(seq_idle), .svc_done(svc_done), .grant_vld(grant_vld),
    .grant_oh(grant_oh), .grant_idx(grant_idx), .grant_burst(grant_burst)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  bit m_ps[N], m_pb[N], m_sw[N];
  bit m_busy, m_vld, m_burst;
  int m_idx, m_g;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < N; c++) begin m_ps[c] = 0; m_pb[c] = 0; m_sw[c] = 0; end
      m_busy = 0; m_vld = 0; m_burst = 0; m_idx = 0;
    end else begin
      m_g = -1;
      if (master_en && seq_idle && !m_busy)
        for (int pass = 0; pass < 2; pass++)
          for (int c = 0; c < N; c++)
            if (m_g < 0 && chan_en[c] && (pass == 1 || hi_prio[c]) &&
                ((m_ps[c] && !burst_only[c]) || m_pb[c] || m_sw[c]))
              m_g = c;
      if (m_busy && svc_done) begin
        m_ps[m_idx] = 0; m_pb[m_idx] = 0; m_busy = 0;
      end
      m_vld = 0;
      if (m_g >= 0) begin
        m_burst = m_pb[m_g] || m_sw[m_g];
        m_sw[m_g] = 0; m_busy = 1; m_idx = m_g; m_vld = 1;
      end
      for (int c = 0; c < N; c++) begin
        if (chan_en[c] && !req_mask[c] && burst_req[c]) m_pb[c] = 1;
        if (chan_en[c] && !req_mask[c] && !burst_only[c] && single_req[c]) m_ps[c] = 1;
        if (chan_en[c] && sw_req[c]) m_sw[c] = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 grant_vld vs model", int'(grant_vld), int'(m_vld));
      chk("R8 grant_oh vs model", int'(grant_oh), m_busy ? (1 << m_idx) : 0);
      if (m_busy) begin
        chk("R7 grant_idx vs model", int'(grant_idx), m_idx);
        chk("R9 grant_burst vs model", int'(grant_burst), int'(m_burst));
      end
    end
  end

  task automatic pulse(input logic [N-1:0] s, input logic [N-1:0] b, input logic [N-1:0] w);
    @(negedge clk);
    single_req = s; burst_req = b; sw_req = w;
    @(negedge clk);
    single_req = '0; burst_req = '0; sw_req = '0;
  endtask

  task automatic finish_svc();
    @(negedge clk); svc_done = 1'b1;
    @(negedge clk); svc_done = 1'b0;
    chk("R10 grant_oh cleared after done", int'(grant_oh), 0);
  endtask

  task automatic quiet(input string tag, input int n);
    repeat (n) begin
      @(negedge clk);
      chk(tag, int'(grant_vld), 0);
    end
  endtask

  task automatic expect_grant(input string tag, input int idx, input int burst);
    int got, gb;
    got = -1; gb = -1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (grant_vld) begin got = int'(grant_idx); gb = int'(grant_burst); break; end
    end
    chk(tag, got, idx);
    chk(tag, gb, burst);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; master_en = 1'b1; seq_idle = 1'b1; svc_done = 1'b0;
    chan_en = '1; req_mask = '0; burst_only = '0; hi_prio = '0;
    single_req = '0; burst_req = '0; sw_req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 grant_vld after reset", int'(grant_vld), 0);
    chk("R1 grant_oh after reset", int'(grant_oh), 0);
    quiet("R1 nothing pending after reset", 3);

    // R7 lowest wins, R9 single vs burst, R10 pending dropped
    pulse(8'h04, 8'h20, 8'h00);
    expect_grant("R7 lowest channel first", 2, 0);
    finish_svc();
    expect_grant("R9 burst channel served next", 5, 1);
    finish_svc();
    quiet("R10 no regrant after done", 4);

    // R6 high priority beats lower number
    hi_prio = 8'h40;
    pulse(8'h42, 8'h00, 8'h00);
    expect_grant("R6 high priority channel", 6, 0);
    finish_svc();
    expect_grant("R6 default channel after", 1, 0);
    finish_svc();
    hi_prio = '0;

    // R2 mask, R4 software bypasses mask
    req_mask = 8'h08;
    pulse(8'h08, 8'h08, 8'h00);
    quiet("R2 masked channel ignored", 5);
    pulse(8'h00, 8'h00, 8'h08);
    expect_grant("R4 software request on masked channel", 3, 1);
    finish_svc();
    req_mask = '0;
    quiet("R4 zero software request idle", 3);

    // R3 burst only
    burst_only = 8'h10;
    pulse(8'h10, 8'h00, 8'h00);
    quiet("R3 single ignored on burst-only", 5);
    pulse(8'h00, 8'h10, 8'h00);
    expect_grant("R3 burst on burst-only", 4, 1);
    finish_svc();
    burst_only = '0;

    // R5 disabled channel
    chan_en = 8'hFE;
    pulse(8'h01, 8'h01, 8'h01);
    quiet("R5 disabled channel latches nothing", 3);
    chan_en = 8'hFF;
    quiet("R5 nothing after re-enable", 3);
    seq_idle = 1'b0;
    pulse(8'h00, 8'h02, 8'h00);
    chan_en = 8'hFD; seq_idle = 1'b1;
    quiet("R5 pending held while disabled", 4);
    chan_en = 8'hFF;
    expect_grant("R5 served after re-enable", 1, 1);
    finish_svc();

    // R8 gating by master enable, idle and in-service
    master_en = 1'b0;
    pulse(8'h00, 8'h80, 8'h00);
    quiet("R8 no grant without master enable", 4);
    master_en = 1'b1;
    expect_grant("R8 grant after master enable", 7, 1);
    pulse(8'h00, 8'h01, 8'h00);
    quiet("R8 no grant while in service", 4);
    finish_svc();
    expect_grant("R8 next grant after done", 0, 1);
    finish_svc();
    seq_idle = 1'b0;
    pulse(8'h00, 8'h04, 8'h00);
    quiet("R8 no grant while sequencer busy", 3);
    seq_idle = 1'b1;
    expect_grant("R8 grant when sequencer idle", 2, 1);
    finish_svc();

    // R12 stray done
    @(negedge clk); svc_done = 1'b1;
    @(negedge clk); svc_done = 1'b0;
    chk("R12 stray done leaves no grant", int'(grant_oh), 0);
    quiet("R12 stray done creates nothing", 2);

    // R11 exact latency
    pulse(8'h00, 8'h20, 8'h00);
    @(negedge clk);
    chk("R11 grant one edge after capture", int'(grant_vld), 1);
    chk("R11 granted index", int'(grant_idx), 5);
    finish_svc();

    // R4 software request held across a busy period, dropped at grant (R10)
    pulse(8'h04, 8'h00, 8'h00);
    expect_grant("R4 first grant", 2, 0);
    pulse(8'h00, 8'h00, 8'h80);
    quiet("R4 soft request waits", 2);
    finish_svc();
    expect_grant("R4 held soft request granted", 7, 1);
    finish_svc();
    quiet("R10 soft request dropped at grant", 4);

    // Randomized run against the model
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      if (cyc % 60 == 0) begin
        chan_en    = 8'($urandom) | 8'($urandom);
        req_mask   = 8'($urandom) & 8'($urandom);
        burst_only = 8'($urandom) & 8'($urandom);
        hi_prio    = 8'($urandom) & 8'($urandom);
      end
      single_req = 8'($urandom) & 8'($urandom) & 8'($urandom);
      burst_req  = 8'($urandom) & 8'($urandom) & 8'($urandom);
      sw_req     = ($urandom % 8 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      seq_idle   = ($urandom % 5 != 0);
      master_en  = ($urandom % 16 != 0);
      svc_done   = ($urandom % 3 == 0);
    end
    @(negedge clk);
    single_req = '0; burst_req = '0; sw_req = '0; svc_done = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule